// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the raster timing for a parallel LCD panel. A divided-down pixel-clock enable drives two chained phase counters. One counter tracks pixels within a line and the other tracks lines within a frame. From their positions the block derives the line sync, the frame sync and a data-enable window. It also exports the raw horizontal and vertical positions, so that a pixel source can line up with the raster.

All timing settings arrive as plain input ports and must be held stable while the block is busy. The horizontal widths and the vertical sync width are given as their real length minus one. The two vertical porches are given as their real line counts, so either porch may be zero. For monochrome or color passive-matrix panels, the active-line field is filled in units of interface transfers rather than pixels. Because this conversion is done before the value reaches the port, the counter logic is the same for every panel type.

Turning the block on starts a frame at its sync line straight away. Turning it off does not cut the raster. The block stays busy and keeps scanning until a programmed number of whole frames has finished. Only then does it drop back to an idle state with every output quiet.

Top module: `lcd_sync_gen`

## Requirements
- R1: With bypass clear, pclk_en_o pulses for one cycle every 2×(clk_div_i+1) core cycles. With bypass set, pclk_en_o stays high on every cycle while busy.
- R2: Each line runs in this order: sync for hsync_m1_i+1 ticks, back porch for hback_m1_i+1 ticks, active for hactive_m1_i+1 ticks, then front porch for hfront_m1_i+1 ticks. The line period is the sum of the four.
- R3: Each frame runs in this order: sync for vsync_m1_i+1 lines, back porch for vback_i lines (zero allowed), active for vactive_m1_i+1 lines, then front porch for vfront_i lines (zero allowed).
- R4: de_o is high only when both counters are inside their active segments. It is high for hactive_m1_i+1 ticks per active line and on vactive_m1_i+1 lines per frame, and it is never high during either sync pulse.
- R5: When its invert input is 1, a sync output is active-low; when the input is 0, it is active-high. The two sync outputs are controlled independently.
- R6: pix_x_o reads 0 on the first tick of line sync and counts up by one each tick. line_y_o reads 0 on the first sync line. At the first active pixel they read (hsync+hback lengths) and (vsync+vback lengths).
- R7: After enable_i is sampled high in idle, busy_o rises on the next cycle. The first output cycle after that shows both syncs active with pix_x_o = 0 and line_y_o = 0.
- R8: With guard_frames_i = G > 0, dropping enable_i keeps busy_o high, with timing still running, through G frame ends. A frame end that falls in the same cycle as the drop is not counted. busy_o falls right after the G-th frame end, with outputs showing the last pixel of the frame.
- R9: With guard_frames_i = 0, busy_o falls one cycle after enable_i is sampled low.
- R10: In idle (from the second idle cycle on), pclk_en_o and de_o are 0, pix_x_o and line_y_o are 0, and each sync output sits at its inactive level.
- R11: Raising enable_i during the guard drain has no effect. The drain completes at its frame boundary, busy_o stays low for exactly one cycle, and a new frame then starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request |
| guard_frames_i | input | GUARD_W | Whole frames to finish after the run request drops |
| clk_div_i | input | DIV_W | Divider code N; pixel period 2×(N+1) |
| bypass_i | input | 1 | Pixel enable on every core cycle |
| hsync_m1_i | input | HPW_W | Line sync width minus one |
| hback_m1_i | input | HPORCH_W | Line back porch minus one |
| hactive_m1_i | input | HSIZE_W | Active ticks per line minus one |
| hfront_m1_i | input | HPORCH_W | Line front porch minus one |
| vsync_m1_i | input | VPW_W | Frame sync lines minus one |
| vback_i | input | VPORCH_W | Frame back porch lines |
| vactive_m1_i | input | VSIZE_W | Active lines minus one |
| vfront_i | input | VPORCH_W | Frame front porch lines |
| hsync_inv_i | input | 1 | Line sync active-low when set |
| vsync_inv_i | input | 1 | Frame sync active-low when set |
| pclk_en_o | output | 1 | Pixel clock enable |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | H_CNT_W | Position within line |
| line_y_o | output | V_CNT_W | Position within frame |
| busy_o | output | 1 | Running or draining |

## Verification
The run request can drop in the same cycle as a frame end. When it does, the power sequencer has to decide whether that frame end counts toward the guard. The bench starts a frame from idle with a known bypassed period and counts exactly one frame length of cycles. It then lowers the request so that the drop and the frame end fall on the same edge. With a guard of one frame, busy must stay high for one more complete frame and not fall at once. A second overlap is a request raised again during the drain: the last guarded frame end and the waiting request meet, and the bench expects busy to go low for exactly one cycle.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  // Run-state of the enable / guard sequencer
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_RUN   = 2'd1,
    PS_DRAIN = 2'd2
  } pwr_state_e;

endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bypass_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_w;
  logic             at_end_w;

  // period 2*(N+1) cycles -> last count 2N+1
  assign last_w   = {div_i, 1'b1};
  assign at_end_w = (cnt_q >= last_w);
  assign tick_o   = run_i && (bypass_i || at_end_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!run_i || bypass_i || at_end_w)  cnt_q <= '0;
    else                                      cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1: divided ticks never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !bypass_i) |=> (!tick_o || bypass_i));

endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] sync_len_i,
  input  logic [CNT_W-1:0] back_len_i,
  input  logic [CNT_W-1:0] act_len_i,
  input  logic [CNT_W-1:0] front_len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             in_sync_o,
  output logic             in_act_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_lo_w;
  logic [CNT_W-1:0] act_hi_w;
  logic [CNT_W-1:0] last_w;
  logic             at_last_w;

  // segment boundaries: sync, back porch, active, front porch
  assign act_lo_w  = sync_len_i + back_len_i;
  assign act_hi_w  = act_lo_w + act_len_i;
  assign last_w    = act_hi_w + front_len_i - CNT_W'(1);
  assign at_last_w = (cnt_q >= last_w);

  assign cnt_o     = cnt_q;
  assign wrap_o    = step_i && at_last_w;
  assign in_sync_o = (cnt_q < sync_len_i);
  assign in_act_o  = (cnt_q >= act_lo_w) && (cnt_q < act_hi_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= at_last_w ? '0 : cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_sync_pkg::*;
#(
  parameter int GUARD_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               frame_end_i,
  input  logic [GUARD_W-1:0] guard_i,
  output logic               busy_o
);

  pwr_state_e         st_q, st_d;
  logic [GUARD_W-1:0] done_q, done_d;
  logic               guard_met_w;

  assign guard_met_w = (guard_i == '0) ||
                       (frame_end_i && ((done_q + GUARD_W'(1)) >= guard_i));

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    case (st_q)
      PS_IDLE: if (en_i) begin
        st_d   = PS_RUN;
        done_d = '0;
      end
      PS_RUN: if (!en_i) begin
        // a frame end in the drop cycle is not counted
        done_d = '0;
        st_d   = (guard_i == '0) ? PS_IDLE : PS_DRAIN;
      end
      PS_DRAIN: begin
        if (guard_met_w)      st_d   = PS_IDLE;
        else if (frame_end_i) done_d = done_q + GUARD_W'(1);
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_IDLE;
      done_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign busy_o = (st_q != PS_IDLE);

  // R7: busy only starts from a sampled run request
  assert_busy_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_i));

  // R8 / R9: busy ends only on a frame end or with a zero guard
  assert_busy_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(frame_end_i || (guard_i == '0)));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int DIV_W    = 8,
  parameter int HPW_W    = 6,
  parameter int HPORCH_W = 8,
  parameter int HSIZE_W  = 11,
  parameter int VPW_W    = 6,
  parameter int VPORCH_W = 8,
  parameter int VSIZE_W  = 11,
  parameter int GUARD_W  = 7,
  localparam int H_MAX_W = (HPW_W > HPORCH_W) ? HPW_W : HPORCH_W,
  localparam int H_CNT_W = ((H_MAX_W > HSIZE_W) ? H_MAX_W : HSIZE_W) + 2,
  localparam int V_MAX_W = (VPW_W > VPORCH_W) ? VPW_W : VPORCH_W,
  localparam int V_CNT_W = ((V_MAX_W > VSIZE_W) ? V_MAX_W : VSIZE_W) + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [GUARD_W-1:0]  guard_frames_i,
  input  logic [DIV_W-1:0]    clk_div_i,
  input  logic                bypass_i,
  input  logic [HPW_W-1:0]    hsync_m1_i,
  input  logic [HPORCH_W-1:0] hback_m1_i,
  input  logic [HSIZE_W-1:0]  hactive_m1_i,
  input  logic [HPORCH_W-1:0] hfront_m1_i,
  input  logic [VPW_W-1:0]    vsync_m1_i,
  input  logic [VPORCH_W-1:0] vback_i,
  input  logic [VSIZE_W-1:0]  vactive_m1_i,
  input  logic [VPORCH_W-1:0] vfront_i,
  input  logic                hsync_inv_i,
  input  logic                vsync_inv_i,
  output logic                pclk_en_o,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic [H_CNT_W-1:0]  pix_x_o,
  output logic [V_CNT_W-1:0]  line_y_o,
  output logic                busy_o
);

  // decode of the mixed field encodings
  function automatic logic [H_CNT_W-1:0] h_span(input logic [H_CNT_W-1:0] code_m1);
    return code_m1 + H_CNT_W'(1);
  endfunction

  function automatic logic [V_CNT_W-1:0] v_span(input logic [V_CNT_W-1:0] code, input logic plus_one);
    return plus_one ? code + V_CNT_W'(1) : code;
  endfunction

  logic               busy_w;
  logic               tick_w;
  logic               line_end_w;
  logic               frame_end_w;
  logic               h_sync_w, h_act_w, v_sync_w, v_act_w;
  logic [H_CNT_W-1:0] h_cnt_w;
  logic [V_CNT_W-1:0] v_cnt_w;

  lcd_pwr_seq #(.GUARD_W(GUARD_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (enable_i),
    .frame_end_i (frame_end_w),
    .guard_i     (guard_frames_i),
    .busy_o      (busy_w)
  );

  lcd_pclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_w),
    .bypass_i (bypass_i),
    .div_i    (clk_div_i),
    .tick_o   (tick_w)
  );

  lcd_axis_ctr #(.CNT_W(H_CNT_W)) u_hctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy_w),
    .step_i      (tick_w),
    .sync_len_i  (h_span(H_CNT_W'(hsync_m1_i))),
    .back_len_i  (h_span(H_CNT_W'(hback_m1_i))),
    .act_len_i   (h_span(H_CNT_W'(hactive_m1_i))),
    .front_len_i (h_span(H_CNT_W'(hfront_m1_i))),
    .cnt_o       (h_cnt_w),
    .wrap_o      (line_end_w),
    .in_sync_o   (h_sync_w),
    .in_act_o    (h_act_w)
  );

  lcd_axis_ctr #(.CNT_W(V_CNT_W)) u_vctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy_w),
    .step_i      (line_end_w),
    .sync_len_i  (v_span(V_CNT_W'(vsync_m1_i), 1'b1)),
    .back_len_i  (v_span(V_CNT_W'(vback_i), 1'b0)),
    .act_len_i   (v_span(V_CNT_W'(vactive_m1_i), 1'b1)),
    .front_len_i (v_span(V_CNT_W'(vfront_i), 1'b0)),
    .cnt_o       (v_cnt_w),
    .wrap_o      (frame_end_w),
    .in_sync_o   (v_sync_w),
    .in_act_o    (v_act_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_en_o <= 1'b0;
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      de_o      <= 1'b0;
      pix_x_o   <= '0;
      line_y_o  <= '0;
    end else begin
      pclk_en_o <= tick_w;
      hsync_o   <= hsync_inv_i ^ (busy_w && h_sync_w);
      vsync_o   <= vsync_inv_i ^ (busy_w && v_sync_w);
      de_o      <= busy_w && h_act_w && v_act_w;
      pix_x_o   <= busy_w ? h_cnt_w : '0;
      line_y_o  <= busy_w ? v_cnt_w : '0;
    end
  end

  assign busy_o = busy_w;

  // R4: data window never overlaps a sync pulse
  assert_de_outside_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ((hsync_o == hsync_inv_i) && (vsync_o == vsync_inv_i)));

  // R10: outputs quiet once idle has lasted a cycle
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> (!pclk_en_o && !de_o && (pix_x_o == '0) && (line_y_o == '0)));

endmodule

// File: tb/lcd_sync_gen_tb.sv
module lcd_sync_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [6:0]  guard = '0;
  logic [7:0]  cdiv = '0;
  logic        byp = 1'b0;
  logic [5:0]  hpw = '0;
  logic [7:0]  hbp = '0;
  logic [10:0] hact = '0;
  logic [7:0]  hfp = '0;
  logic [5:0]  vpw = '0;
  logic [7:0]  vbp = '0;
  logic [10:0] vact = '0;
  logic [7:0]  vfp = '0;
  logic        hinv = 1'b0;
  logic        vinv = 1'b0;

  logic        pe, hs, vs, de, busy;
  logic [12:0] px;
  logic [12:0] ly;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_sync_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .guard_frames_i(guard),
    .clk_div_i(cdiv), .bypass_i(byp),
    .hsync_m1_i(hpw), .hback_m1_i(hbp), .hactive_m1_i(hact), .hfront_m1_i(hfp),
    .vsync_m1_i(vpw), .vback_i(vbp), .vactive_m1_i(vact), .vfront_i(vfp),
    .hsync_inv_i(hinv), .vsync_inv_i(vinv),
    .pclk_en_o(pe), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .pix_x_o(px), .line_y_o(ly), .busy_o(busy)
  );

  // ---------------- measurement monitor (negedge sampling) ----------------
  int cyc = 0;
  int hs_rise = 0, hs_width = 0, hs_period = 0;
  int vs_rise = 0, vs_width = 0, vs_period = 0;
  int de_rise = 0, de_width = 0, de_off = 0, de_x = 0;
  int de_lines = 0, de_lines_last = 0, first_de_off = 0, first_de_y = 0;
  int pe_last = 0, pe_gap = 0;
  bit first_de = 1'b0;
  bit hs_q = 1'b0, vs_q = 1'b0, de_q = 1'b0;

  always @(negedge clk) begin
    bit hs_a, vs_a;
    cyc++;
    hs_a = hs ^ hinv;
    vs_a = vs ^ vinv;
    if (hs_a && !hs_q) begin hs_period = cyc - hs_rise; hs_rise = cyc; end
    if (!hs_a && hs_q) hs_width = cyc - hs_rise;
    if (vs_a && !vs_q) begin
      vs_period = cyc - vs_rise; vs_rise = cyc;
      de_lines_last = de_lines; de_lines = 0; first_de = 1'b1;
    end
    if (!vs_a && vs_q) vs_width = cyc - vs_rise;
    if (de && !de_q) begin
      de_rise = cyc; de_off = cyc - hs_rise; de_x = int'(px); de_lines++;
      if (first_de) begin first_de_off = cyc - vs_rise; first_de_y = int'(ly); first_de = 1'b0; end
    end
    if (!de && de_q) de_width = cyc - de_rise;
    if (pe) begin pe_gap = cyc - pe_last; pe_last = cyc; end
    hs_q = hs_a; vs_q = vs_a; de_q = de;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int d, input bit b, input int h0, input int h1, input int h2, input int h3,
                         input int v0, input int v1, input int v2, input int v3, input bit hi, input bit vi);
    cdiv = 8'(d); byp = b;
    hpw = 6'(h0); hbp = 8'(h1); hact = 11'(h2); hfp = 8'(h3);
    vpw = 6'(v0); vbp = 8'(v1); vact = 11'(v2); vfp = 8'(v3);
    hinv = hi; vinv = vi;
  endtask

  function automatic int period_c();
    return byp ? 1 : 2 * (int'(cdiv) + 1);
  endfunction
  function automatic int line_ticks();
    return int'(hpw) + int'(hbp) + int'(hact) + int'(hfp) + 4;
  endfunction
  function automatic int frame_lines();
    return int'(vpw) + 1 + int'(vbp) + int'(vact) + 1 + int'(vfp);
  endfunction

  task automatic stop_now();
    guard = '0;
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    chk(req, "idle pclk_en", int'(pe), 0);
    chk(req, "idle de", int'(de), 0);
    chk(req, "idle pix_x", int'(px), 0);
    chk(req, "idle line_y", int'(ly), 0);
    chk("R5", "idle hsync level", int'(hs), int'(hinv));
    chk("R5", "idle vsync level", int'(vs), int'(vinv));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", int'(busy), 0);
    chk("R10", "reset de", int'(de), 0);
    chk("R10", "reset pclk_en", int'(pe), 0);
    chk("R10", "reset pix_x", int'(px), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R10");
  endtask

  task automatic t_timing();
    int p, lt, fl, hsl, hbl;
    p = period_c(); lt = line_ticks(); fl = frame_lines();
    hsl = int'(hpw) + 1; hbl = int'(hbp) + 1;
    guard = '0;
    en = 1'b1;
    repeat (3 * fl * lt * p + 20) @(negedge clk);
    chk("R1", "pclk_en spacing", pe_gap, p);
    chk("R2", "line sync width", hs_width, hsl * p);
    chk("R2", "line period", hs_period, lt * p);
    chk("R2", "sync start to active start", de_off, (hsl + hbl) * p);
    chk("R4", "active width per line", de_width, (int'(hact) + 1) * p);
    chk("R3", "frame sync width", vs_width, (int'(vpw) + 1) * lt * p);
    chk("R3", "frame period", vs_period, fl * lt * p);
    chk("R3", "frame start to first active pixel", first_de_off,
        ((int'(vpw) + 1 + int'(vbp)) * lt + hsl + hbl) * p);
    chk("R4", "active lines per frame", de_lines_last, int'(vact) + 1);
    chk("R6", "pix_x at first active pixel", de_x, hsl + hbl);
    chk("R6", "line_y at first active line", first_de_y, int'(vpw) + 1 + int'(vbp));
    en = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R10");
  endtask

  task automatic t_start();
    en = 1'b1;
    @(negedge clk);
    chk("R7", "busy one cycle after request", int'(busy), 1);
    @(negedge clk);
    chk("R7", "first hsync active", int'(hs ^ hinv), 1);
    chk("R7", "first vsync active", int'(vs ^ vinv), 1);
    chk("R7", "first pix_x", int'(px), 0);
    chk("R7", "first line_y", int'(ly), 0);
    stop_now();
  endtask

  task automatic t_drain_mid();
    int lt, fl, n, rises;
    bit prev;
    lt = line_ticks(); fl = frame_lines();
    guard = 7'd2;
    en = 1'b1;
    repeat (fl * lt + fl * lt / 2) @(negedge clk);
    en = 1'b0;
    prev = vs ^ vinv; rises = 0; n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin
      if ((vs ^ vinv) && !prev) rises++;
      prev = vs ^ vinv;
      n++;
      @(negedge clk);
    end
    chk("R8", "frames started during 2-frame drain", rises, 1);
    chk("R8", "pix_x when drain ends", int'(px), lt - 1);
    chk("R8", "line_y when drain ends", int'(ly), fl - 1);
    @(negedge clk);
    check_idle("R10");
  endtask

  task automatic t_drain_edge();
    int f, n;
    f = line_ticks() * frame_lines();   // bypassed: one cycle per tick
    guard = 7'd1;
    en = 1'b1;
    @(negedge clk);
    while (!busy) @(negedge clk);
    repeat (f - 1) @(negedge clk);
    en = 1'b0;                          // sampled on the frame-end edge
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (busy && n < 5000);
    chk("R8", "drain length when drop meets frame end", n, f + 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_guard0();
    guard = '0;
    en = 1'b1;
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9", "busy after drop with zero guard", int'(busy), 0);
    @(negedge clk);
    check_idle("R9");
  endtask

  task automatic t_reenable();
    int lt, fl, n;
    lt = line_ticks(); fl = frame_lines();
    guard = 7'd2;
    en = 1'b1;
    repeat (50) @(negedge clk);
    en = 1'b0;
    repeat (30) @(negedge clk);
    en = 1'b1;                          // ignored while draining
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R11", "pix_x when drain ends despite request", int'(px), lt - 1);
    chk("R11", "line_y when drain ends despite request", int'(ly), fl - 1);
    @(negedge clk);
    chk("R11", "busy back after one idle cycle", int'(busy), 1);
    stop_now();
  endtask

  // ---------------- main ----------------
  initial begin
    t_reset();
    // divided clock, active-high line sync, active-low frame sync
    set_cfg(1, 1'b0, 2, 1, 7, 0, 0, 2, 3, 1, 1'b0, 1'b1);
    t_timing();
    // bypass, zero vertical porches, opposite polarities
    set_cfg(5, 1'b1, 0, 3, 9, 2, 1, 0, 2, 0, 1'b1, 1'b0);
    t_timing();
    // same raster with a wider divider
    set_cfg(2, 1'b0, 0, 3, 9, 2, 1, 0, 2, 0, 1'b1, 1'b0);
    t_timing();
    set_cfg(5, 1'b1, 0, 3, 9, 2, 1, 0, 2, 0, 1'b1, 1'b0);
    t_start();
    t_drain_mid();
    t_drain_edge();
    t_guard0();
    t_reenable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule